// File: doc/BRIEF.md
# Card clock timing sequencer

This block retunes the clocks of four storage-card channels. A request names a channel, an operation and a frequency in kHz. The block turns the frequency into one of five supported tiers, looks up the sample-phase, drive-phase and divider codes for that tier, and writes them into two shared 32-bit control words. It does this with a fixed run of read-modify-write cycles on a synchronous register port. Each field changes only while that channel's clock enable is off.

Requests are serialized. A request is accepted only in IDLE, while `req_ready` is high. Each request ends with a one-cycle `done`. With it the block reports the chosen tier and the parent frequency that tier needs, or it raises `err`. A separate combinational path maps a parent frequency to the card clock it yields.

The controller has four states. IDLE accepts a request. It goes to READ_WORD when the request is valid, or straight to REPORT when the request is rejected. READ_WORD always goes to WRITE_WORD. WRITE_WORD goes back to READ_WORD for the next step, or to REPORT after the final step. REPORT always returns to IDLE. The step order is GATE, SAMPLE, DRIVE, DIVIDE, UNGATE.

Top module: `cardclk_seq`

## Requirements
- R1: The operation code on `req_op` is 0 for a rounding request. A rounding request picks a tier from `req_khz`:
  - up to 26000 gives 25000 kHz with a 180000 kHz parent;
  - up to 52000 gives 50000 kHz with a 360000 kHz parent;
  - up to 100000 gives 100000 kHz with a 720000 kHz parent;
  - anything higher gives 180000 kHz with a 1440000 kHz parent.
- R2: Channel 1 alone has a low-speed tier. On that channel a rounding request of at most 13000 kHz gives 13000 kHz with a 26000 kHz parent. This test comes before all the other thresholds.
- R3: The codes written, as (sample, drive, divider), are:
  - 13000 kHz: (3, 1, 1);
  - 25000 kHz: (13, 6, 6);
  - 50000 kHz: (3, 6, 6);
  - 100000 kHz: (6, 4, 6);
  - 180000 kHz: (6, 4, 7).
- R4: An accepted request makes five read-then-write pairs on the same word, in the order enable clear, sample, drive, divider, enable set. A write always follows its read in the next cycle.
- R5: Each write changes only the bits of its own field. Code bits beyond the field width are dropped.
- R6: The fields of channel c start at bit 12*c of the 64-bit pair {word1, word0}. Bit p lies in word p/32 at bit p%32. Within a channel, the enable is at offset 0, the divider at offsets 1..3, the drive at offsets 4..7 and the sample at offsets 8..11.
- R7: A prepare request (`req_op` = 2) programs 13000 kHz on channel 1 and 25000 kHz on every other channel.
- R8: An exact-set request (`req_op` = 1) must name one of the five tier frequencies. Otherwise it is rejected. A rejected request, or `req_op` = 3, raises `err` with `done` one cycle after acceptance, touches no register, and reports 0 as tier and parent.
- R9: `rate_out_khz` maps 26000, 180000, 360000, 720000 and 1440000 on `rate_parent_khz` to 13000, 25000, 50000, 100000 and 180000. Every other value passes through unchanged.
- R10: `req_ready` is low from acceptance until `done`. A request held while the block is busy is ignored.
- R11: For an accepted programming request, `done` is a single-cycle pulse in the 11th cycle after the acceptance edge. In that cycle `tier_khz` and `parent_khz` show the chosen tier.
- R12: While `rst_n` is low (synchronous, active low), the block is in IDLE with `req_ready` high and `done`, `err`, `reg_rd` and `reg_wr` low. Reset aborts a running sequence.
- R13: The channel's enable bit is low in the word state produced by each of the sample, drive and divider writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted at this edge |
| req_op | input | 2 | 0 round, 1 exact set, 2 prepare, 3 reserved |
| req_ch | input | 2 | Channel index |
| req_khz | input | 32 | Requested frequency in kHz |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected (valid with done) |
| tier_khz | output | 32 | Chosen card clock in kHz |
| parent_khz | output | 32 | Parent frequency the tier needs, in kHz |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | 1 | Control word index |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, one cycle after reg_rd |
| rate_parent_khz | input | 32 | Parent frequency to translate |
| rate_out_khz | output | 32 | Card clock produced by that parent |

## Verification
The cycle of the acceptance edge is counted as cycle 0. A rejected request must show `done` with `err` in cycle 1, and a programming request in cycle 11. The bench counts falling edges from acceptance and compares that count exactly, not only that `done` appears. Each register write is judged at the falling edge before the edge that commits it. At that point the bench rebuilds the word pair as it will be after the write and checks the target field, the enable bit and every untouched bit. The final words are compared in the `done` cycle, after the last write has landed. The rate translation is combinational and is sampled in the same cycle its input is driven.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

    typedef enum logic [2:0] {
        TIER_13, TIER_25, TIER_50, TIER_100, TIER_180
    } tier_e;

    typedef enum logic [2:0] {
        STEP_GATE, STEP_SAMPLE, STEP_DRIVE, STEP_DIVIDE, STEP_UNGATE
    } step_e;

    typedef enum logic [1:0] {
        OP_ROUND, OP_SET, OP_PREPARE, OP_RSVD
    } op_e;

    localparam int CH_STRIDE = 12;
    localparam int EN_OFF    = 0;
    localparam int DIV_OFF   = 1;
    localparam int DIV_W     = 3;
    localparam int DRV_OFF   = 4;
    localparam int DRV_W     = 4;
    localparam int SAM_OFF   = 8;
    localparam int SAM_W     = 4;
    localparam int N_TIERS   = 5;

    function automatic logic [31:0] fn_tier_khz(tier_e t);
        unique case (t)
            TIER_13:  return 32'd13000;
            TIER_25:  return 32'd25000;
            TIER_50:  return 32'd50000;
            TIER_100: return 32'd100000;
            TIER_180: return 32'd180000;
            default:  return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] fn_parent_khz(tier_e t);
        unique case (t)
            TIER_13:  return 32'd26000;
            TIER_25:  return 32'd180000;
            TIER_50:  return 32'd360000;
            TIER_100: return 32'd720000;
            TIER_180: return 32'd1440000;
            default:  return 32'd0;
        endcase
    endfunction

    function automatic logic [3:0] fn_sample_code(tier_e t);
        unique case (t)
            TIER_13:  return 4'd3;
            TIER_25:  return 4'd13;
            TIER_50:  return 4'd3;
            default:  return 4'd6;
        endcase
    endfunction

    function automatic logic [3:0] fn_drive_code(tier_e t);
        unique case (t)
            TIER_13:  return 4'd1;
            TIER_25,
            TIER_50:  return 4'd6;
            default:  return 4'd4;
        endcase
    endfunction

    function automatic logic [3:0] fn_divide_code(tier_e t);
        unique case (t)
            TIER_13:  return 4'd1;
            TIER_180: return 4'd7;
            default:  return 4'd6;
        endcase
    endfunction

endpackage

// File: rtl/cardclk_tier_pick.sv
module cardclk_tier_pick
    import cardclk_pkg::*;
#(
    parameter int FREQ_W    = 32,
    parameter int N_CH      = 4,
    parameter int LOWSPD_CH = 1,
    localparam int CH_W     = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  op_e               op,
    input  logic [CH_W-1:0]   ch,
    input  logic [FREQ_W-1:0] khz,
    output tier_e             tier,
    output logic              bad
);
    logic low_ch;
    assign low_ch = (ch == CH_W'(LOWSPD_CH));

    always_comb begin
        tier = TIER_25;
        bad  = 1'b0;
        unique case (op)
            OP_ROUND: begin
                if (low_ch && khz <= FREQ_W'(13000))  tier = TIER_13;
                else if (khz <= FREQ_W'(26000))       tier = TIER_25;
                else if (khz <= FREQ_W'(52000))       tier = TIER_50;
                else if (khz <= FREQ_W'(100000))      tier = TIER_100;
                else                                  tier = TIER_180;
            end
            OP_SET: begin
                if (khz == FREQ_W'(13000))       tier = TIER_13;
                else if (khz == FREQ_W'(25000))  tier = TIER_25;
                else if (khz == FREQ_W'(50000))  tier = TIER_50;
                else if (khz == FREQ_W'(100000)) tier = TIER_100;
                else if (khz == FREQ_W'(180000)) tier = TIER_180;
                else                             bad  = 1'b1;
            end
            OP_PREPARE: tier = low_ch ? TIER_13 : TIER_25;
            default:    bad  = 1'b1;
        endcase
    end
endmodule

// File: rtl/cardclk_field_rmw.sv
module cardclk_field_rmw
    import cardclk_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int N_CH    = 4,
    localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int N_WORDS = (N_CH * CH_STRIDE + WORD_W - 1) / WORD_W,
    localparam int ADDR_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int POS_W  = 16,
    localparam int LO_W   = $clog2(WORD_W)
) (
    input  logic [CH_W-1:0]   ch,
    input  step_e             step,
    input  tier_e             tier,
    input  logic [WORD_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] wdata
);
    logic [POS_W-1:0]  off;
    logic [POS_W-1:0]  pos;
    logic [LO_W-1:0]   lo;
    logic [3:0]        fw;
    logic [3:0]        code;
    logic [WORD_W-1:0] mask;

    always_comb begin
        unique case (step)
            STEP_SAMPLE: begin off = POS_W'(SAM_OFF); fw = 4'(SAM_W); code = fn_sample_code(tier); end
            STEP_DRIVE:  begin off = POS_W'(DRV_OFF); fw = 4'(DRV_W); code = fn_drive_code(tier);  end
            STEP_DIVIDE: begin off = POS_W'(DIV_OFF); fw = 4'(DIV_W); code = fn_divide_code(tier); end
            STEP_UNGATE: begin off = POS_W'(EN_OFF);  fw = 4'd1;      code = 4'd1;                 end
            default:     begin off = POS_W'(EN_OFF);  fw = 4'd1;      code = 4'd0;                 end
        endcase
    end

    assign pos   = POS_W'(ch) * POS_W'(CH_STRIDE) + off;
    assign addr  = ADDR_W'(pos / POS_W'(WORD_W));
    assign lo    = LO_W'(pos % POS_W'(WORD_W));
    assign mask  = (WORD_W'(1) << fw) - WORD_W'(1);
    assign wdata = (rdata & ~(mask << lo)) | ((WORD_W'(code) & mask) << lo);
endmodule

// File: rtl/cardclk_rate_map.sv
module cardclk_rate_map
    import cardclk_pkg::*;
#(
    parameter int FREQ_W = 32
) (
    input  logic [FREQ_W-1:0] parent_khz,
    output logic [FREQ_W-1:0] out_khz
);
    logic [N_TIERS-1:0] hit;
    logic [FREQ_W-1:0]  tier_out [N_TIERS];

    for (genvar t = 0; t < N_TIERS; t++) begin : g_tier
        assign hit[t]      = (parent_khz == FREQ_W'(fn_parent_khz(tier_e'(3'(t)))));
        assign tier_out[t] = FREQ_W'(fn_tier_khz(tier_e'(3'(t))));
    end

    always_comb begin
        out_khz = parent_khz;
        for (int t = 0; t < N_TIERS; t++) begin
            if (hit[t]) out_khz = tier_out[t];
        end
    end
endmodule

// File: rtl/cardclk_seq.sv
module cardclk_seq
    import cardclk_pkg::*;
#(
    parameter int N_CH      = 4,
    parameter int WORD_W    = 32,
    parameter int FREQ_W    = 32,
    parameter int LOWSPD_CH = 1,
    localparam int CH_W     = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int N_WORDS  = (N_CH * CH_STRIDE + WORD_W - 1) / WORD_W,
    localparam int ADDR_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [CH_W-1:0]   req_ch,
    input  logic [FREQ_W-1:0] req_khz,
    output logic              done,
    output logic              err,
    output logic [FREQ_W-1:0] tier_khz,
    output logic [FREQ_W-1:0] parent_khz,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] reg_rdata,
    input  logic [FREQ_W-1:0] rate_parent_khz,
    output logic [FREQ_W-1:0] rate_out_khz
);
    typedef enum logic [1:0] {ST_IDLE, ST_READ_WORD, ST_WRITE_WORD, ST_REPORT} state_e;

    state_e          state;
    step_e           step_q;
    tier_e           tier_q;
    logic            bad_q;
    logic [CH_W-1:0] ch_q;

    tier_e pick_tier;
    logic  pick_bad;
    logic [ADDR_W-1:0] fld_addr;
    logic [WORD_W-1:0] fld_wdata;

    cardclk_tier_pick #(.FREQ_W(FREQ_W), .N_CH(N_CH), .LOWSPD_CH(LOWSPD_CH)) u_pick (
        .op   (op_e'(req_op)),
        .ch   (req_ch),
        .khz  (req_khz),
        .tier (pick_tier),
        .bad  (pick_bad)
    );

    cardclk_field_rmw #(.WORD_W(WORD_W), .N_CH(N_CH)) u_field (
        .ch    (ch_q),
        .step  (step_q),
        .tier  (tier_q),
        .rdata (reg_rdata),
        .addr  (fld_addr),
        .wdata (fld_wdata)
    );

    cardclk_rate_map #(.FREQ_W(FREQ_W)) u_rate (
        .parent_khz (rate_parent_khz),
        .out_khz    (rate_out_khz)
    );

    // state register and transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            step_q <= STEP_GATE;
            tier_q <= TIER_25;
            bad_q  <= 1'b0;
            ch_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        ch_q   <= req_ch;
                        tier_q <= pick_tier;
                        bad_q  <= pick_bad;
                        step_q <= STEP_GATE;
                        state  <= pick_bad ? ST_REPORT : ST_READ_WORD;
                    end
                end
                ST_READ_WORD: state <= ST_WRITE_WORD;
                ST_WRITE_WORD: begin
                    if (step_q == STEP_UNGATE) begin
                        state <= ST_REPORT;
                    end else begin
                        step_q <= step_e'(step_q + 3'd1);
                        state  <= ST_READ_WORD;
                    end
                end
                ST_REPORT: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state == ST_IDLE);
        reg_rd     = (state == ST_READ_WORD);
        reg_wr     = (state == ST_WRITE_WORD);
        reg_addr   = fld_addr;
        reg_wdata  = fld_wdata;
        done       = (state == ST_REPORT);
        err        = done && bad_q;
        tier_khz   = bad_q ? '0 : FREQ_W'(fn_tier_khz(tier_q));
        parent_khz = bad_q ? '0 : FREQ_W'(fn_parent_khz(tier_q));
    end
endmodule

// File: rtl/cardclk_seq_chk.sv
module cardclk_seq_chk #(
    parameter int ADDR_W = 1,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              done,
    input logic              err,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [WORD_W-1:0] reg_rdata
);
    a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> (reg_wr && reg_addr == $past(reg_addr)));

    a_r4_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));

    a_r10_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(reg_rd || reg_wr));

    a_r5_narrow_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> ($countones(reg_wdata ^ reg_rdata) <= 4));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    a_r8_err_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(req_ready));
endmodule

bind cardclk_seq cardclk_seq_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .err       (err),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
);

// File: tb/sim_cardclk_seq.sv
`timescale 1ns/1ps
module sim_cardclk_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [1:0]  req_ch = 2'd0;
    logic [31:0] req_khz = 32'd0;
    logic        done, err;
    logic [31:0] tier_khz, parent_khz;
    logic        reg_rd, reg_wr;
    logic [0:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata = 32'd0;
    logic [31:0] rate_parent_khz = 32'd0;
    logic [31:0] rate_out_khz;

    logic [31:0] mem [2] = '{32'hA5A5_5A5A, 32'h0F0F_F0F0};
    logic [63:0] model;

    int checks = 0;
    int errors = 0;
    int mon_ch = 0, mon_khz = 0, wr_idx = 0, rd_cnt = 0;
    logic [63:0] m_view, m_new, m_mask;

    always #10 clk = ~clk;

    cardclk_seq u0 (.*);

    // register file model: synchronous read, synchronous write
    always_ff @(posedge clk) begin
        if (reg_rd) reg_rdata <= mem[reg_addr];
        if (reg_wr) mem[reg_addr] <= reg_wdata;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] codes(input int khz); // {sample, drive, divider}
        case (khz)
            13000:   return {4'd3,  4'd1, 4'd1};
            25000:   return {4'd13, 4'd6, 4'd6};
            50000:   return {4'd3,  4'd6, 4'd6};
            100000:  return {4'd6,  4'd4, 4'd6};
            default: return {4'd6,  4'd4, 4'd7};
        endcase
    endfunction

    function automatic int parent_of(input int khz);
        case (khz)
            13000:   return 26000;
            25000:   return 180000;
            50000:   return 360000;
            100000:  return 720000;
            180000:  return 1440000;
            default: return 0;
        endcase
    endfunction

    function automatic logic [63:0] put(input logic [63:0] v, input int pos, input int w, input int val);
        for (int b = 0; b < w; b++) v[pos + b] = 1'((val >> b) & 1);
        return v;
    endfunction

    function automatic logic [63:0] program_model(input logic [63:0] v, input int ch, input int khz);
        logic [11:0] c;
        c = codes(khz);
        v = put(v, 12 * ch + 8, 4, int'(c[11:8]));
        v = put(v, 12 * ch + 4, 4, int'(c[7:4]));
        v = put(v, 12 * ch + 1, 3, int'(c[3:0]));
        v = put(v, 12 * ch, 1, 1);
        return v;
    endfunction

    // write monitor: judge each write before the edge that commits it (R4, R5, R6, R13, R3)
    always @(negedge clk) begin
        if (rst_n && reg_wr) begin
            automatic int off, w, code, pos;
            automatic logic [11:0] c = codes(mon_khz);
            case (wr_idx)
                0:       begin off = 0; w = 1; code = 0; end
                1:       begin off = 8; w = 4; code = int'(c[11:8]); end
                2:       begin off = 4; w = 4; code = int'(c[7:4]); end
                3:       begin off = 1; w = 3; code = int'(c[3:0]); end
                default: begin off = 0; w = 1; code = 1; end
            endcase
            pos    = 12 * mon_ch + off;
            m_view = {mem[1], mem[0]};
            m_new  = m_view;
            if (pos >= 32) m_new[63:32] = reg_wdata; else m_new[31:0] = reg_wdata;
            m_mask = ((64'd1 << w) - 64'd1) << pos;
            chk(32'(reg_addr) == pos / 32, "R6 write word", longint'(reg_addr), pos / 32);
            chk(((m_new ^ m_view) & ~m_mask) == 64'd0, "R5 untouched bits", longint'(m_new), longint'(m_view));
            chk(int'((m_new >> pos) & ((64'd1 << w) - 64'd1)) == code, "R3 R4 field code",
                longint'((m_new >> pos) & ((64'd1 << w) - 64'd1)), code);
            chk(m_new[12 * mon_ch] == (wr_idx >= 4), "R13 enable during step",
                longint'(m_new[12 * mon_ch]), longint'(wr_idx >= 4));
            wr_idx++;
        end
        if (rst_n && reg_rd) rd_cnt++;
    end

    task automatic run_req(input int op, input int ch, input int khz, input bit exp_err,
                           input int exp_khz, input bit noise);
        int cyc;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready when idle", req_ready, 1);
        mon_ch = ch; mon_khz = exp_khz; wr_idx = 0; rd_cnt = 0;
        req_valid = 1'b1; req_op = 2'(op); req_ch = 2'(ch); req_khz = 32'(khz);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        if (!exp_err) chk(req_ready == 1'b0, "R10 ready low while busy", req_ready, 0);
        while (!done && cyc < 20) begin
            if (noise && cyc >= 2 && cyc <= 4) begin
                req_valid = 1'b1; req_op = 2'd2; req_ch = 2'd3;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        chk(cyc == (exp_err ? 1 : 11), "R11 R8 done cycle", cyc, exp_err ? 1 : 11);
        chk(err == exp_err, "R8 err flag", err, exp_err);
        chk(tier_khz == 32'(exp_err ? 0 : exp_khz), "R1 R2 R7 tier", tier_khz, exp_err ? 0 : exp_khz);
        chk(parent_khz == 32'(exp_err ? 0 : parent_of(exp_khz)), "R1 R2 parent",
            parent_khz, exp_err ? 0 : parent_of(exp_khz));
        chk(wr_idx == (exp_err ? 0 : 5) && rd_cnt == (exp_err ? 0 : 5), "R4 R8 access count",
            wr_idx * 100 + rd_cnt, exp_err ? 0 : 505);
        if (!exp_err) model = program_model(model, ch, exp_khz);
        chk({mem[1], mem[0]} == model, "R5 R6 final words", longint'({mem[1], mem[0]}), longint'(model));
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1, "R11 done single pulse", done, 0);
    endtask

    // {op, ch, khz, err, expected tier khz}
    localparam logic [68:0] VEC [16] = '{
        {2'd0, 2'd0, 32'd10000,  1'b0, 32'd25000},
        {2'd0, 2'd1, 32'd10000,  1'b0, 32'd13000},
        {2'd0, 2'd1, 32'd13000,  1'b0, 32'd13000},
        {2'd0, 2'd1, 32'd13001,  1'b0, 32'd25000},
        {2'd0, 2'd2, 32'd26000,  1'b0, 32'd25000},
        {2'd0, 2'd3, 32'd26001,  1'b0, 32'd50000},
        {2'd0, 2'd0, 32'd52000,  1'b0, 32'd50000},
        {2'd0, 2'd2, 32'd100000, 1'b0, 32'd100000},
        {2'd0, 2'd3, 32'd100001, 1'b0, 32'd180000},
        {2'd1, 2'd0, 32'd50000,  1'b0, 32'd50000},
        {2'd1, 2'd1, 32'd12000,  1'b1, 32'd0},
        {2'd2, 2'd1, 32'd0,      1'b0, 32'd13000},
        {2'd2, 2'd3, 32'd999999, 1'b0, 32'd25000},
        {2'd1, 2'd2, 32'd180000, 1'b0, 32'd180000},
        {2'd3, 2'd0, 32'd25000,  1'b1, 32'd0},
        {2'd1, 2'd3, 32'd13000,  1'b0, 32'd13000}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model = {mem[1], mem[0]};
        // R12 reset state
        repeat (3) @(negedge clk);
        chk(req_ready && !done && !err && !reg_rd && !reg_wr, "R12 reset outputs",
            {req_ready, done, err, reg_rd, reg_wr}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done && !err, "R12 idle after reset", {req_ready, done, err}, 3'b100);

        // vector table: R1 R2 R3 R7 R8
        for (int i = 0; i < 16; i++) begin
            run_req(int'(VEC[i][68:67]), int'(VEC[i][66:65]), int'(VEC[i][64:33]),
                    VEC[i][32], int'(VEC[i][31:0]), 1'b0);
        end

        // R10: requests held while busy are ignored
        run_req(0, 0, 180001, 1'b0, 180000, 1'b1);
        repeat (3) begin
            @(negedge clk);
            chk(!reg_rd && !reg_wr && req_ready, "R10 no extra sequence", reg_rd, 0);
        end

        // R9 rate translation
        for (int i = 0; i < 7; i++) begin
            automatic int pin  = (i == 0) ? 26000 : (i == 1) ? 180000 : (i == 2) ? 360000 :
                                 (i == 3) ? 720000 : (i == 4) ? 1440000 : (i == 5) ? 50000 : 0;
            automatic int pexp = (i == 0) ? 13000 : (i == 1) ? 25000 : (i == 2) ? 50000 :
                                 (i == 3) ? 100000 : (i == 4) ? 180000 : pin;
            @(negedge clk);
            rate_parent_khz = 32'(pin);
            #1;
            chk(rate_out_khz == 32'(pexp), "R9 rate map", rate_out_khz, pexp);
        end

        // R12: reset aborts a running sequence
        @(negedge clk);
        mon_ch = 2; mon_khz = 100000; wr_idx = 0;
        req_valid = 1'b1; req_op = 2'd1; req_ch = 2'd2; req_khz = 32'd100000;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(req_ready && !done && !err && !reg_wr, "R12 abort by reset",
            {req_ready, done, err, reg_wr}, 4'b1000);
        rst_n = 1'b1;
        run_req(2, 2, 0, 1'b0, 25000, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule